// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It walks a two-level page table held in ordinary memory. The page size is 1 KB, so the low 10 bits of the logical address pass through unchanged as the offset. The 22-bit page number above the offset splits into two indices:

- a 12-bit outer index, taken from the top bits;
- a 10-bit inner index, taken from the bits just above the offset.

A table-base input gives the location of the outer table. The base is captured together with each request.

Each walk makes exactly two word reads on a simple request/response memory port. The first read fetches the outer entry, which locates an inner table. The second read fetches the inner entry, which holds the frame number. Both entries are checked for validity and for write permission. A bad entry ends the walk with a fault, and the fault reports the level where it was found. A good walk returns the frame number joined with the offset.

The block accepts a new request only while it is idle. It does not cache translations and never writes to the tables.

Top module: `pt_walker`

## Requirements
- R1: After reset, reqReady is 1 and both respValid and memReqValid are 0.
- R2: A request is taken only when reqValid and reqReady are both high. reqReady is high only while the walker is idle. A reqValid raised during a walk causes no extra read and no extra response.
- R3: The first read of a walk targets the captured table base plus 4 times the outer index. The outer index is logical-address bits 31:20.
- R4: The second read targets the inner-table base plus 4 times the inner index. The inner-table base is bits 31:10 of the outer entry followed by ten zero bits. The inner index is logical-address bits 19:10.
- R5: An outer entry with bit 0 (valid) clear ends the walk with respFault=1 and respFaultLevel=0. No second read is issued.
- R6: A write request whose outer entry has bit 1 (writable) clear ends the walk with respFault=1 and respFaultLevel=0. The same entry does not fault for a read.
- R7: An inner entry with bit 0 clear ends the walk with respFault=1 and respFaultLevel=1.
- R8: A write request whose inner entry has bit 1 clear faults with respFaultLevel=1. A read of the same page succeeds.
- R9: On success, respPaddr is bits 31:10 of the inner entry followed by logical-address bits 9:0. On a fault, respPaddr is 0.
- R10: Every result is a respValid pulse of exactly one cycle. It comes in the cycle after the memory response that ends the walk. A successful walk makes exactly two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqAddr | input | 32 | Logical address to translate |
| reqWrite | input | 1 | Access is a write (1) or a read (0) |
| ptBase | input | 32 | Byte address of the outer table |
| memReqValid | output | 1 | Read request, held until the response |
| memReqAddr | output | 32 | Byte address of the entry being read |
| memRspValid | input | 1 | One-cycle read response strobe |
| memRspData | input | 32 | Entry word returned by memory |
| respValid | output | 1 | One-cycle result strobe |
| respFault | output | 1 | Result is a fault |
| respFaultLevel | output | 1 | Fault found in outer (0) or inner (1) entry |
| respPaddr | output | 32 | Translated physical address |

## Verification
The assertions assume a well-behaved memory. It answers each held read with exactly one single-cycle memRspValid, and it never answers while no read is outstanding. They also take ptBase and reqAddr to be meaningful only in the cycle a request is accepted. The bench memory model keeps to these assumptions. It waits for memReqValid, answers after a fixed two-cycle delay, and drops the strobe before looking for the next read. The driver raises reqValid during a busy walk with a corrupted address and a zero base, so that a wrongly taken request or a late sample of the inputs would show up in the results.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_OUTER,
    ST_READ_INNER,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic loadReq;
    logic loadOuter;
    logic loadInner;
    logic selInner;
    logic showPaddr;
  } walkStrobe_t;

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  logic        entryFault,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        respValid,
  output logic        respFault,
  output logic        respFaultLevel
);

  walkState_t state, stateNext;
  logic faultLvl, faultLvlNext;

  always_comb begin
    stateNext    = state;
    faultLvlNext = faultLvl;
    unique case (state)
      ST_IDLE:       if (reqValid) stateNext = ST_READ_OUTER;
      ST_READ_OUTER: if (memRspValid) begin
                       if (entryFault) begin
                         stateNext    = ST_FAULT;
                         faultLvlNext = 1'b0;
                       end else begin
                         stateNext = ST_READ_INNER;
                       end
                     end
      ST_READ_INNER: if (memRspValid) begin
                       if (entryFault) begin
                         stateNext    = ST_FAULT;
                         faultLvlNext = 1'b1;
                       end else begin
                         stateNext = ST_DONE;
                       end
                     end
      ST_DONE:       stateNext = ST_IDLE;
      ST_FAULT:      stateNext = ST_IDLE;
      default:       stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      faultLvl <= 1'b0;
    end else begin
      state    <= stateNext;
      faultLvl <= faultLvlNext;
    end
  end

  always_comb begin
    strobe.loadReq   = (state == ST_IDLE) && reqValid;
    strobe.loadOuter = (state == ST_READ_OUTER) && memRspValid;
    strobe.loadInner = (state == ST_READ_INNER) && memRspValid;
    strobe.selInner  = (state == ST_READ_INNER);
    strobe.showPaddr = (state == ST_DONE);
  end

  assign reqReady       = (state == ST_IDLE);
  assign memReqValid    = (state == ST_READ_OUTER) || (state == ST_READ_INNER);
  assign respValid      = (state == ST_DONE) || (state == ST_FAULT);
  assign respFault      = (state == ST_FAULT);
  assign respFaultLevel = (state == ST_FAULT) && faultLvl;

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 10,
  parameter int INNER_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              entryFault,
  output logic [ADDR_W-1:0] respPaddr
);

  localparam int OUTER_W   = ADDR_W - OFFSET_W - INNER_W;
  localparam int FRAME_W   = ADDR_W - OFFSET_W;
  localparam int VALID_BIT = 0;
  localparam int WRITE_BIT = 1;

  logic [ADDR_W-1:0]  vaReg, baseReg;
  logic               wrReg;
  logic [FRAME_W-1:0] tableReg, frameReg;

  logic [OUTER_W-1:0]  outerIdx;
  logic [INNER_W-1:0]  innerIdx;
  logic [OFFSET_W-1:0] pageOffset;
  logic [ADDR_W-1:0]   outerAddr, innerAddr;
  logic                unusedEntryBits;

  assign outerIdx   = vaReg[ADDR_W-1 -: OUTER_W];
  assign innerIdx   = vaReg[OFFSET_W +: INNER_W];
  assign pageOffset = vaReg[OFFSET_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg    <= '0;
      baseReg  <= '0;
      wrReg    <= 1'b0;
      tableReg <= '0;
      frameReg <= '0;
    end else begin
      if (strobe.loadReq) begin
        vaReg   <= reqAddr;
        baseReg <= ptBase;
        wrReg   <= reqWrite;
      end
      if (strobe.loadOuter) tableReg <= memRspData[ADDR_W-1:OFFSET_W];
      if (strobe.loadInner) frameReg <= memRspData[ADDR_W-1:OFFSET_W];
    end
  end

  assign outerAddr  = baseReg + ADDR_W'({outerIdx, 2'b00});
  assign innerAddr  = {tableReg, OFFSET_W'(0)} + ADDR_W'({innerIdx, 2'b00});
  assign memReqAddr = strobe.selInner ? innerAddr : outerAddr;

  assign entryFault = !memRspData[VALID_BIT] || (wrReg && !memRspData[WRITE_BIT]);
  assign unusedEntryBits = ^memRspData[OFFSET_W-1:WRITE_BIT+1];

  assign respPaddr = strobe.showPaddr ? {frameReg, pageOffset} : '0;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 10,
  parameter int INNER_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] ptBase,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              respValid,
  output logic              respFault,
  output logic              respFaultLevel,
  output logic [ADDR_W-1:0] respPaddr
);

  walkStrobe_t strobe;
  logic        entryFault;

  pt_walker_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .reqValid       (reqValid),
    .memRspValid    (memRspValid),
    .entryFault     (entryFault),
    .strobe         (strobe),
    .reqReady       (reqReady),
    .memReqValid    (memReqValid),
    .respValid      (respValid),
    .respFault      (respFault),
    .respFaultLevel (respFaultLevel)
  );

  pt_walker_dp #(
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W),
    .INNER_W  (INNER_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .ptBase     (ptBase),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .entryFault (entryFault),
    .respPaddr  (respPaddr)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 10,
  parameter int INNER_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [ADDR_W-1:0] ptBase,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              respValid,
  input logic              respFault,
  input logic [ADDR_W-1:0] respPaddr
);

  localparam int OUTER_W = ADDR_W - OFFSET_W - INNER_W;

  // R2: never ready while a read is outstanding
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R2: an accepted request starts a read in the next cycle
  a_r2_accept_reads: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> memReqValid);

  // R3: first read address comes from the sampled base and outer index
  a_r3_outer_addr: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=>
      memReqAddr == $past(ptBase) + ADDR_W'({$past(reqAddr[ADDR_W-1 -: OUTER_W]), 2'b00}));

  // R9: a fault never reports an address
  a_r9_fault_zero_addr: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> (respPaddr == '0));

  // R10: result is a single-cycle pulse
  a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  // R10: result follows a memory response by one cycle
  a_r10_resp_after_rsp: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(memRspValid));

  // R5: no read is outstanding while a result is shown
  a_r5_no_read_at_result: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !memReqValid);

endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] ptBase = '0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        respValid, respFault, respFaultLevel;
  logic [31:0] respPaddr;

  always #2.5 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .ptBase(ptBase),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .respValid(respValid), .respFault(respFault),
    .respFaultLevel(respFaultLevel), .respPaddr(respPaddr)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // table memory model
  logic [31:0] mem [logic [31:0]];
  int          readCnt = 0;
  logic [31:0] readAddr [2];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memReqValid) begin
        if (readCnt < 2) readAddr[readCnt] = memReqAddr;
        readCnt++;
        repeat (2) @(negedge clk);
        memRspData  = rd(memReqAddr);
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  typedef struct {
    logic        fault;
    logic        lvl;
    logic [31:0] pa;
    int          reads;
    logic [31:0] a0;
    logic [31:0] a1;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  // scoreboard monitor
  bit prevResp = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevResp) check(respValid == 1'b0, "R10 single-cycle respValid", 32'(respValid), 32'd0);
      prevResp = respValid;
      if (respValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(respFault == e.fault, {e.tag, " fault flag"}, 32'(respFault), 32'(e.fault));
          if (e.fault) check(respFaultLevel == e.lvl, {e.tag, " fault level"}, 32'(respFaultLevel), 32'(e.lvl));
          check(respPaddr == e.pa, {e.tag, " R9 paddr"}, respPaddr, e.pa);
          check(readCnt == e.reads, {e.tag, " R10 read count"}, 32'(readCnt), 32'(e.reads));
          check(readAddr[0] == e.a0, {e.tag, " R3 outer read addr"}, readAddr[0], e.a0);
          if (e.reads == 2) check(readAddr[1] == e.a1, {e.tag, " R4 inner read addr"}, readAddr[1], e.a1);
        end
      end
    end
  end

  task automatic doReq(input logic [31:0] va, input bit wr, input logic [31:0] base,
                       input string tag, input bit poke);
    exp_t e;
    logic [31:0] e0, e1;
    e.tag = tag; e.fault = 1'b0; e.lvl = 1'b0; e.pa = '0; e.a1 = '0;
    e.a0 = base + {18'd0, va[31:20], 2'b00};
    e0 = rd(e.a0);
    e.reads = 1;
    if (!e0[0] || (wr && !e0[1])) begin
      e.fault = 1'b1; e.lvl = 1'b0;
    end else begin
      e.reads = 2;
      e.a1 = {e0[31:10], 10'd0} + {20'd0, va[19:10], 2'b00};
      e1 = rd(e.a1);
      if (!e1[0] || (wr && !e1[1])) begin
        e.fault = 1'b1; e.lvl = 1'b1;
      end else begin
        e.pa = {e1[31:10], va[9:0]};
      end
    end
    expQ.push_back(e);
    readCnt = 0;
    readAddr[0] = '0; readAddr[1] = '0;
    check(reqReady == 1'b1, {tag, " R2 ready before request"}, 32'(reqReady), 32'd1);
    reqAddr = va; reqWrite = wr; ptBase = base; reqValid = 1'b1;
    @(negedge clk);
    if (poke) begin
      reqAddr = va ^ 32'h00F0_0155; reqWrite = ~wr; ptBase = 32'h0;
      check(reqReady == 1'b0, {tag, " R2 busy not ready"}, 32'(reqReady), 32'd0);
      repeat (4) @(negedge clk);
    end
    reqValid = 1'b0;
    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] BASE_A = 32'h0001_0000;
  localparam logic [31:0] BASE_B = 32'h0005_0000;

  initial begin
    // outer idx 3 -> inner table at 0x20000
    mem[BASE_A + 32'd12]   = (32'h80 << 10) | 32'h3;
    mem[32'h0002_0014]     = (32'h2ABCD << 10) | 32'h3;    // inner 5: rw
    mem[32'h0002_001C]     = (32'h3FFFFF << 10) | 32'h1;   // inner 7: ro
    // outer idx 9 read-only -> inner table at 0x24000
    mem[BASE_A + 32'd36]   = (32'h90 << 10) | 32'h1;
    mem[32'h0002_4008]     = (32'h155 << 10) | 32'h3;      // inner 2
    // outer idx 0xFFF -> inner table at 0x400
    mem[BASE_A + 32'h3FFC] = (32'h1 << 10) | 32'h3;
    mem[32'h0000_13FC]     = (32'h12345 << 10) | 32'h1;    // inner 0x3FF
    // second base
    mem[BASE_B + 32'd12]   = (32'hA0 << 10) | 32'h1;
    mem[32'h0002_8014]     = (32'h777 << 10) | 32'h1;

    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1 reqReady in reset", 32'(reqReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reqReady after reset", 32'(reqReady), 32'd1);
    check(respValid == 1'b0, "R1 respValid after reset", 32'(respValid), 32'd0);
    check(memReqValid == 1'b0, "R1 memReqValid after reset", 32'(memReqValid), 32'd0);

    doReq((32'd3 << 20) | (32'd5 << 10) | 32'h123, 1'b0, BASE_A, "R9 read success", 1'b0);
    doReq((32'd3 << 20) | (32'd5 << 10) | 32'h2A0, 1'b1, BASE_A, "R9 write success", 1'b0);
    doReq((32'd7 << 20) | (32'd1 << 10) | 32'h010, 1'b0, BASE_A, "R5 outer invalid", 1'b0);
    doReq((32'd9 << 20) | (32'd2 << 10) | 32'h001, 1'b0, BASE_A, "R6 read via ro outer", 1'b0);
    doReq((32'd9 << 20) | (32'd2 << 10) | 32'h001, 1'b1, BASE_A, "R6 write via ro outer", 1'b0);
    doReq((32'd3 << 20) | (32'd6 << 10) | 32'h044, 1'b0, BASE_A, "R7 inner invalid", 1'b0);
    doReq((32'd3 << 20) | (32'd7 << 10) | 32'h3FF, 1'b0, BASE_A, "R8 read ro page", 1'b0);
    doReq((32'd3 << 20) | (32'd7 << 10) | 32'h3FF, 1'b1, BASE_A, "R8 write ro page", 1'b0);
    doReq((32'hFFF << 20) | (32'h3FF << 10),       1'b0, BASE_A, "R4 top indices", 1'b0);
    doReq((32'd3 << 20) | (32'd5 << 10) | 32'h055, 1'b0, BASE_B, "R3 other base", 1'b0);
    doReq((32'd3 << 20) | (32'd5 << 10) | 32'h0AA, 1'b0, BASE_A, "R2 poke while busy", 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule